// File: doc/BRIEF.md
# Digital Current-Mode Loop Compensator

This block computes the duty command for a digitally controlled step-down converter. It runs one update per switching period, at a rate near 1 MHz. Each update takes two quantized samples. The first is a signed voltage-error code in which one step stands for 10 mV of output error. The second is an unsigned inductor-current code in which one step stands for about 93 mA, spanning roughly 0 to 1.4 A.

A PID filter turns the error into an inductor-current target. It has no multiplier: every coefficient product is read from a constant table indexed by a quantized code. The table contents are fixed integer coefficients, standing in for a prewarped bilinear mapping of a continuous design. A predictive current law then subtracts the scaled current sample from the target and adds a bias. The result is clamped to a programmable window and delivered as an 8-bit word for a counter-comparator modulator.

A one-cycle strobe starts each update. Two clock edges later, the duty word is loaded and a one-cycle valid pulse is raised. The integrator saturates at its signed limits. It also freezes whenever the previous output was clamped and the new error would push further into that clamp.

Top module: `cm_loop_comp`

## Requirements
- R1: While `rst_n` is low, `duty_o` loads `duty_min_i` and `valid_o` is 0. Reset also clears the integrator, the stored previous error and both clamp flags, so the first update after reset acts on an integrator of 0 and a previous error of 0.
- R2: `err_i` is a 4-bit two's complement code, from -8 to +7. A positive code means the output is below its reference, and it raises the duty.
- R3: Each update uses three table products. The proportional term is 4·e. The derivative term is 2·(e − e_prev), where e_prev is the error code of the previous update. The integrator adds 1·e. The tables are indexed by the error code and by the 5-bit error difference.
- R4: The raw duty is 128 + P + I + D − 8·c. Here I is the integrator value after this update, and c is the unsigned 4-bit `cur_i` code.
- R5: `duty_o` is the raw duty limited to the window `duty_min_i`..`duty_max_i`. If the raw duty is below the minimum it takes the minimum; otherwise, if it is above the maximum, it takes the maximum.
- R6: The integrator saturates inside the range -128..+127.
- R7: The integrator holds its value during an update in two cases: the previous update was clamped at the maximum and the new integrator increment is positive, or the previous update was clamped at the minimum and the increment is negative.
- R8: A strobe sampled at rising edge T0 loads `duty_o` and sets `valid_o` at edge T0+2. `valid_o` is high for one cycle. Between updates, `duty_o` is held.
- R9: Strobes on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 1 | One-cycle update strobe |
| err_i | input | 4 | Signed voltage-error code |
| cur_i | input | 4 | Unsigned inductor-current code |
| duty_min_i | input | 8 | Lower duty limit |
| duty_max_i | input | 8 | Upper duty limit |
| duty_o | output | 8 | Duty word for the modulator |
| valid_o | output | 1 | Pulse marking a new duty word |

## Verification
Two functions can act in the same update: the output clamp, and the integrator that it freezes. The bench drives a large positive error against a low maximum for several updates. Each of these updates both clamps and asks the integrator to grow. It then reverses the error and checks that the duty leaves the clamp at once, matching a reference model in which the integrator never wound up. A second pair can also coincide: integrator saturation while the output is unclamped. The bench provokes it with a wide window and a high current code, and checks that the duty settles at the value the saturated integrator implies.

// File: rtl/cm_loop_comp.sv
module cm_loop_comp #(
  parameter int ERR_W  = 4,
  parameter int CUR_W  = 4,
  parameter int DUTY_W = 8,
  parameter int ACC_W  = 8,
  parameter int SUM_W  = 12,
  parameter int KP     = 4,
  parameter int KI     = 1,
  parameter int KD     = 2,
  parameter int CUR_K  = 8,
  parameter int BIAS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [DUTY_W-1:0] duty_min_i,
  input  logic [DUTY_W-1:0] duty_max_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              valid_o
);
  localparam int NE = 1 << ERR_W;
  localparam int ND = 1 << (ERR_W + 1);
  localparam int NC = 1 << CUR_W;
  localparam int ACC_MAX = (1 << (ACC_W - 1)) - 1;
  localparam int ACC_MIN = -(1 << (ACC_W - 1));

  logic signed [SUM_W-1:0] p_tab [NE];
  logic signed [SUM_W-1:0] i_tab [NE];
  logic signed [SUM_W-1:0] d_tab [ND];
  logic signed [SUM_W-1:0] c_tab [NC];

  for (genvar k = 0; k < NE; k++) begin : g_err_tab
    localparam int SV = (k >= NE / 2) ? k - NE : k;
    assign p_tab[k] = SUM_W'(KP * SV);
    assign i_tab[k] = SUM_W'(KI * SV);
  end
  for (genvar k = 0; k < ND; k++) begin : g_diff_tab
    localparam int SV = (k >= ND / 2) ? k - ND : k;
    assign d_tab[k] = SUM_W'(KD * SV);
  end
  for (genvar k = 0; k < NC; k++) begin : g_cur_tab
    assign c_tab[k] = SUM_W'(CUR_K * k);
  end

  logic [ERR_W-1:0] e_prev;
  logic [ERR_W:0]   e_diff;
  assign e_diff = {err_i[ERR_W-1], err_i} - {e_prev[ERR_W-1], e_prev};

  logic s1;
  logic signed [SUM_W-1:0] p_q, i_q, d_q, c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      e_prev <= '0;
      p_q <= '0; i_q <= '0; d_q <= '0; c_q <= '0;
    end else begin
      s1 <= sample_i;
      if (sample_i) begin
        e_prev <= err_i;
        p_q <= p_tab[err_i];
        i_q <= i_tab[err_i];
        d_q <= d_tab[e_diff];
        c_q <= c_tab[cur_i];
      end
    end
  end

  logic signed [SUM_W-1:0] acc, acc_sum, acc_nxt, raw, mn, mx;
  logic hi_q, lo_q, hold, raw_lo, raw_hi;

  assign acc_sum = acc + i_q;
  assign hold = (hi_q && i_q > 0) || (lo_q && i_q < 0);
  always_comb begin
    if (hold) acc_nxt = acc;
    else if (acc_sum > SUM_W'(ACC_MAX)) acc_nxt = SUM_W'(ACC_MAX);
    else if (acc_sum < SUM_W'(ACC_MIN)) acc_nxt = SUM_W'(ACC_MIN);
    else acc_nxt = acc_sum;
  end

  assign raw = SUM_W'(BIAS) + p_q + acc_nxt + d_q - c_q;
  assign mn = $signed({{(SUM_W-DUTY_W){1'b0}}, duty_min_i});
  assign mx = $signed({{(SUM_W-DUTY_W){1'b0}}, duty_max_i});
  assign raw_lo = raw < mn;
  assign raw_hi = !raw_lo && (raw > mx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      valid_o <= 1'b0;
      duty_o <= duty_min_i;
    end else begin
      valid_o <= s1;
      if (s1) begin
        acc <= acc_nxt;
        hi_q <= raw_hi;
        lo_q <= raw_lo;
        duty_o <= raw_lo ? duty_min_i : raw_hi ? duty_max_i : raw[DUTY_W-1:0];
      end
    end
  end

  // R8: result follows the strobe by two edges
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> ##1 valid_o);
  // R8: duty only moves with a valid pulse
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(duty_o) || $past(!rst_n));
  // R5: delivered duty respects the window
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && duty_min_i <= duty_max_i) |-> (duty_o >= duty_min_i && duty_o <= duty_max_i));
  // R7: integrator frozen while pushing into the upper clamp
  p_no_windup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1 && hi_q && i_q > 0) |=> acc == $past(acc));
  // R6: integrator stays inside its signed range
  p_acc_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= SUM_W'(ACC_MAX) && acc >= SUM_W'(ACC_MIN));
endmodule

// File: tb/cm_loop_comp_tb.sv
module cm_loop_comp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b0;
  logic [3:0] err_i = '0;
  logic [3:0] cur_i = '0;
  logic [7:0] duty_min_i = 8'd0;
  logic [7:0] duty_max_i = 8'd255;
  logic [7:0] duty_o;
  logic valid_o;

  always #5 clk = ~clk;

  cm_loop_comp dut_i (.clk, .rst_n, .sample_i, .err_i, .cur_i,
                      .duty_min_i, .duty_max_i, .duty_o, .valid_o);

  int checks = 0, fails = 0;
  int m_acc, m_ep;
  bit m_hi, m_lo;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int e, input int c);
    int p, i, d, a, raw, mn, mx;
    p = 4 * e; i = e; d = 2 * (e - m_ep); m_ep = e;
    a = m_acc;
    if (!((m_hi && i > 0) || (m_lo && i < 0))) begin
      a = m_acc + i;
      if (a > 127) a = 127;
      if (a < -128) a = -128;
    end
    m_acc = a;
    raw = 128 + p + a + d - 8 * c;
    mn = duty_min_i; mx = duty_max_i;
    m_lo = raw < mn;
    m_hi = !m_lo && raw > mx;
    return m_lo ? mn : m_hi ? mx : raw;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = 0; m_ep = 0; m_hi = 0; m_lo = 0;
  endtask

  task automatic upd(input int e, input int c, input string tag);
    int exp;
    @(negedge clk);
    sample_i = 1'b1; err_i = 4'(e); cur_i = 4'(c);
    @(negedge clk);
    sample_i = 1'b0;
    check(valid_o == 1'b0, {tag, " early valid R8"}, valid_o, 0);
    @(negedge clk);
    exp = model(e, c);
    check(valid_o == 1'b1, {tag, " valid R8"}, valid_o, 1);
    check(duty_o == 8'(exp), tag, duty_o, exp);
  endtask

  task automatic t_reset();
    duty_min_i = 8'd10; duty_max_i = 8'd250;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(duty_o == 8'd10, "R1 reset duty", duty_o, 10);
    check(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    do_reset();
    check(duty_o == 8'd10, "R1 duty after reset", duty_o, 10);
    upd(0, 0, "R1 first update zero state");
    check(duty_o == 8'd128, "R1 bias only", duty_o, 128);
  endtask

  task automatic t_pid();
    do_reset();
    upd(3, 2, "R3 step +3");
    check(duty_o == 8'd133, "R3 value 133", duty_o, 133);
    upd(3, 2, "R3 hold +3");
    upd(-4, 1, "R2 negative error");
    upd(-4, 1, "R2 negative repeat");
    upd(0, 0, "R3 derivative back to zero");
  endtask

  task automatic t_cur();
    do_reset();
    for (int c = 0; c < 16; c += 5) upd(1, c, "R4 current sweep");
  endtask

  task automatic t_clamp();
    do_reset();
    duty_min_i = 8'd100; duty_max_i = 8'd140;
    upd(7, 0, "R5 clamp max");
    check(duty_o == 8'd140, "R5 max value", duty_o, 140);
    upd(-8, 15, "R5 clamp min");
    check(duty_o == 8'd100, "R5 min value", duty_o, 100);
  endtask

  task automatic t_windup();
    do_reset();
    duty_min_i = 8'd0; duty_max_i = 8'd140;
    for (int k = 0; k < 6; k++) upd(7, 0, "R7 push into max");
    upd(-2, 4, "R7 release");
    check(duty_o < 8'd140, "R7 leaves clamp at once", duty_o, 139);
    upd(0, 4, "R7 settle");
  endtask

  task automatic t_sat();
    do_reset();
    duty_min_i = 8'd0; duty_max_i = 8'd255;
    for (int k = 0; k < 22; k++) upd(7, 15, "R6 integrate");
    check(duty_o == 8'd163, "R6 saturated duty", duty_o, 163);
  endtask

  task automatic t_idle();
    logic [7:0] held;
    held = duty_o;
    repeat (5) begin
      @(negedge clk);
      err_i = 4'd5; cur_i = 4'd3;
      check(valid_o == 1'b0, "R8 idle valid", valid_o, 0);
      check(duty_o == held, "R8 idle hold", duty_o, held);
    end
  endtask

  task automatic t_b2b();
    int e1, e2;
    do_reset();
    duty_min_i = 8'd0; duty_max_i = 8'd255;
    @(negedge clk);
    sample_i = 1'b1; err_i = 4'd2; cur_i = 4'd1;
    @(negedge clk);
    err_i = 4'hD; cur_i = 4'd6;
    @(negedge clk);
    sample_i = 1'b0;
    e1 = model(2, 1);
    check(valid_o && duty_o == 8'(e1), "R9 first result", duty_o, e1);
    @(negedge clk);
    e2 = model(-3, 6);
    check(valid_o && duty_o == 8'(e2), "R9 second result", duty_o, e2);
    @(negedge clk);
    check(valid_o == 1'b0, "R9 pulse ends", valid_o, 0);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_pid();
    t_idle();
    t_cur();
    t_clamp();
    t_windup();
    t_sat();
    t_b2b();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule